// File: doc/BRIEF.md
# Memory Backfill Address Decoder

This block is the select logic of an 8-bit ISA memory expansion card that fills the gap between a host's installed memory and the 640 KB or 704 KB mark. It looks at the 20-bit bus address and the active-low memory read and write strobes. From these it produces an active-low chip enable for a single 512 KB SRAM, the 19 SRAM address lines, and the enable and direction controls for a data-bus transceiver. It also drives two active-low activity indicators.

Decoding happens in two stages of 1-of-4 decoders. The first stage splits the 1 MB space on the two top address bits into four 256 KB slices. The second quarter (0x40000-0x7FFFF) is claimed whole. The third quarter (0x80000-0xBFFFF) enables a second decoder on bits 17..16, which splits it into four 64 KB pages. Pages 0x8xxxx and 0x9xxxx are always claimed. Page 0xAxxxx is claimed only when the configuration input is high, and page 0xBxxxx is never claimed.

The SRAM address is the bus address with bit 19 dropped. This swaps the SRAM halves: the whole-slice region uses the upper half of the SRAM, and the paged region uses the lower half. Every output is combinational.

Top module: `isa_backfill_decoder`

## Requirements
- R1: For any address with bits 19..18 equal to 01, ram_ce_n is 0.
- R2: For addresses with bits 19..16 equal to 0x8 or 0x9, ram_ce_n is 0.
- R3: For addresses with bits 19..16 equal to 0xA, ram_ce_n equals the inverse of opt_page_en: it is 0 only when opt_page_en is 1.
- R4: For addresses with bits 19..16 equal to 0xB, or with bits 19..18 equal to 00 or 11, ram_ce_n is 1 regardless of the other inputs.
- R5: ram_addr always equals bus_addr bits 18..0, so 0x40000-0x7FFFF maps to SRAM 0x40000-0x7FFFF and 0x80000-0xAFFFF maps to SRAM 0x00000-0x2FFFF.
- R6: xcvr_en_n always equals ram_ce_n, and xcvr_dir always equals mem_rd_n (0 means the card drives the bus).
- R7: sys_led_n is 0 exactly when bits 19..18 are 00 or 11 and at least one of mem_rd_n and mem_wr_n is 0.
- R8: vid_led_n is 0 exactly when bits 19..16 are 0xB and at least one of mem_rd_n and mem_wr_n is 0.
- R9: When mem_rd_n and mem_wr_n are both 1, sys_led_n and vid_led_n are both 1 for every address, while ram_ce_n still follows R1 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_addr | input | 20 | Bus address, bit 19 most significant |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| opt_page_en | input | 1 | 1 lets page 0xAxxxx select the card |
| ram_ce_n | output | 1 | SRAM chip enable, active low |
| ram_addr | output | 19 | SRAM address |
| xcvr_en_n | output | 1 | Data transceiver enable, active low |
| xcvr_dir | output | 1 | Data transceiver direction |
| sys_led_n | output | 1 | Host-memory activity indicator, active low |
| vid_led_n | output | 1 | Video-page activity indicator, active low |

## Verification
The block has no stored state, so a wrong select term shows up at the ports as soon as the inputs settle. It appears as a chip enable that is low on a page it should leave alone, or high on a page it should claim. It can also appear as an indicator that lights in the wrong region. Sweeping all sixteen 64 KB pages under both jumper settings and both strobe states exposes any swapped decoder output, any missing gate, or jumper gating of the wrong polarity on the very next sample.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int ADDR_W   = 20;
  localparam int RAM_W    = ADDR_W - 1;
  localparam int SEL_W    = 2;
  localparam int N_OUT    = 1 << SEL_W;
  localparam int SLICE_LO = ADDR_W - SEL_W;      // bits 19..18
  localparam int PAGE_LO  = SLICE_LO - SEL_W;    // bits 17..16

  localparam int SLICE_HOST_LO  = 0;
  localparam int SLICE_DIRECT   = 1;
  localparam int SLICE_SPLIT    = 2;
  localparam int SLICE_HOST_HI  = 3;
  localparam int PAGE_FIXED_0   = 0;
  localparam int PAGE_FIXED_1   = 1;
  localparam int PAGE_OPTIONAL  = 2;
  localparam int PAGE_VIDEO     = 3;

  function automatic logic [SEL_W-1:0] slice_field(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SEL_W];
  endfunction

  function automatic logic [SEL_W-1:0] page_field(input logic [ADDR_W-1:0] a);
    return a[SLICE_LO-1 -: SEL_W];
  endfunction

  function automatic logic [RAM_W-1:0] ram_map(input logic [ADDR_W-1:0] a);
    return a[RAM_W-1:0];
  endfunction
endpackage

// File: rtl/bf_quad_decode.sv
module bf_quad_decode #(
  parameter int SEL_W = 2,
  localparam int N_OUT = 1 << SEL_W
) (
  input  logic             en_n,
  input  logic [SEL_W-1:0] sel,
  output logic [N_OUT-1:0] y_n
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign y_n[i] = en_n | (sel != SEL_W'(i));
  end

  always_comb begin
    if (!$isunknown({en_n, sel})) begin
      a_r4_one_cold: assert ($countones(~y_n) <= 1)
        else $error("decoder asserted more than one output");
    end
  end
endmodule

// File: rtl/bf_select_merge.sv
module bf_select_merge
  import bf_pkg::*;
(
  input  logic [N_OUT-1:0] slice_n,
  input  logic [N_OUT-1:0] page_n,
  input  logic             opt_en,
  output logic             opt_term_n,
  output logic             ce_n
);
  assign opt_term_n = page_n[PAGE_OPTIONAL] | ~opt_en;
  assign ce_n = slice_n[SLICE_DIRECT] & page_n[PAGE_FIXED_0]
              & page_n[PAGE_FIXED_1] & opt_term_n;

  always_comb begin
    if (!$isunknown({page_n, opt_en})) begin
      if (!opt_en) begin
        a_r3_opt_term_idle: assert (opt_term_n)
          else $error("optional page term active with jumper off");
      end
      if (!page_n[PAGE_VIDEO]) begin
        a_r4_video_no_ce: assert (ce_n)
          else $error("video page selected the card");
      end
    end
  end
endmodule

// File: rtl/bf_indicator.sv
module bf_indicator
  import bf_pkg::*;
#(
  parameter bit QUALIFY = 1'b1
) (
  input  logic [N_OUT-1:0] slice_n,
  input  logic             video_n,
  input  logic             rd_n,
  input  logic             wr_n,
  output logic             sys_n,
  output logic             vid_n
);
  logic host_raw_n;
  logic strobe_idle;

  assign host_raw_n  = slice_n[SLICE_HOST_LO] & slice_n[SLICE_HOST_HI];
  assign strobe_idle = rd_n & wr_n;

  if (QUALIFY) begin : g_qual
    assign sys_n = host_raw_n | strobe_idle;
    assign vid_n = video_n | strobe_idle;
  end else begin : g_raw
    assign sys_n = host_raw_n;
    assign vid_n = video_n;
  end

  always_comb begin
    if (!$isunknown({sys_n, vid_n})) begin
      a_r7_leds_exclusive: assert (sys_n | vid_n)
        else $error("both indicators lit");
    end
  end
endmodule

// File: rtl/isa_backfill_decoder.sv
module isa_backfill_decoder
  import bf_pkg::*;
#(
  parameter bit QUALIFY_LEDS = 1'b1
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              mem_rd_n,
  input  logic              mem_wr_n,
  input  logic              opt_page_en,
  output logic              ram_ce_n,
  output logic [RAM_W-1:0]  ram_addr,
  output logic              xcvr_en_n,
  output logic              xcvr_dir,
  output logic              sys_led_n,
  output logic              vid_led_n
);
  logic [N_OUT-1:0] slice_sel_n;
  logic [N_OUT-1:0] page_sel_n;
  logic             opt_term_n;

  bf_quad_decode #(.SEL_W(SEL_W)) u_slice (
    .en_n (1'b0),
    .sel  (slice_field(bus_addr)),
    .y_n  (slice_sel_n)
  );

  bf_quad_decode #(.SEL_W(SEL_W)) u_page (
    .en_n (slice_sel_n[SLICE_SPLIT]),
    .sel  (page_field(bus_addr)),
    .y_n  (page_sel_n)
  );

  bf_select_merge u_merge (
    .slice_n    (slice_sel_n),
    .page_n     (page_sel_n),
    .opt_en     (opt_page_en),
    .opt_term_n (opt_term_n),
    .ce_n       (ram_ce_n)
  );

  bf_indicator #(.QUALIFY(QUALIFY_LEDS)) u_ind (
    .slice_n (slice_sel_n),
    .video_n (page_sel_n[PAGE_VIDEO]),
    .rd_n    (mem_rd_n),
    .wr_n    (mem_wr_n),
    .sys_n   (sys_led_n),
    .vid_n   (vid_led_n)
  );

  assign ram_addr  = ram_map(bus_addr);
  assign xcvr_en_n = ram_ce_n;
  assign xcvr_dir  = mem_rd_n;

  always_comb begin
    if (!$isunknown({bus_addr, mem_rd_n, mem_wr_n, opt_page_en})) begin
      if (bus_addr[19:18] == 2'b01) begin
        a_r1_direct_slice: assert (!ram_ce_n)
          else $error("direct slice not claimed");
      end
      if (bus_addr[19:17] == 3'b100) begin
        a_r2_fixed_pages: assert (!ram_ce_n)
          else $error("fixed page not claimed");
      end
      if (bus_addr[19:16] == 4'hA) begin
        a_r3_optional_page: assert (ram_ce_n == !opt_page_en)
          else $error("optional page jumper ignored");
      end
      if (!sys_led_n) begin
        a_r7_sys_no_ce: assert (ram_ce_n && !(mem_rd_n && mem_wr_n))
          else $error("system indicator while card selected");
      end
      if (mem_rd_n && mem_wr_n) begin
        a_r9_idle_dark: assert (sys_led_n && vid_led_n)
          else $error("indicator lit with no strobe");
      end
    end
  end
endmodule

// File: tb/sim_isa_backfill_decoder.sv
`timescale 1ns/1ps
module sim_isa_backfill_decoder;
  logic        clk = 1'b0;
  logic [19:0] bus_addr;
  logic        mem_rd_n, mem_wr_n, opt_page_en;
  logic        ram_ce_n, xcvr_en_n, xcvr_dir, sys_led_n, vid_led_n;
  logic [18:0] ram_addr;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  isa_backfill_decoder u0 (
    .bus_addr(bus_addr), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .opt_page_en(opt_page_en), .ram_ce_n(ram_ce_n), .ram_addr(ram_addr),
    .xcvr_en_n(xcvr_en_n), .xcvr_dir(xcvr_dir),
    .sys_led_n(sys_led_n), .vid_led_n(vid_led_n)
  );

  function automatic bit covered(input int page, input bit cfg);
    return (page >= 4 && page <= 9) || (page == 10 && cfg);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%05h act=%0h exp=%0h", req, bus_addr, act, exp);
    end
  endtask

  task automatic apply(input logic [19:0] a, input bit rd_n, input bit wr_n, input bit cfg);
    @(negedge clk);
    bus_addr = a; mem_rd_n = rd_n; mem_wr_n = wr_n; opt_page_en = cfg;
    #1;
  endtask

  task automatic t_idle_state;
    apply(20'h00000, 1'b1, 1'b1, 1'b0);
    check("R4 idle ce", ram_ce_n, 1);
    check("R9 idle sys", sys_led_n, 1);
    check("R9 idle vid", vid_led_n, 1);
  endtask

  task automatic t_sweep_ce;
    for (int cfg = 0; cfg < 2; cfg++)
      for (int p = 0; p < 16; p++)
        for (int off = 0; off < 2; off++) begin
          logic [19:0] a = {p[3:0], (off != 0) ? 16'hFFFF : 16'h0000};
          apply(a, 1'b0, 1'b1, cfg[0]);
          if (p >= 4 && p <= 7) check("R1 direct slice", ram_ce_n, 0);
          else if (p == 8 || p == 9) check("R2 fixed page", ram_ce_n, 0);
          else if (p == 10) check("R3 optional page", ram_ce_n, !cfg[0]);
          else check("R4 unclaimed", ram_ce_n, 1);
          check("R6 xcvr en", xcvr_en_n, !covered(p, cfg[0]));
        end
  endtask

  task automatic t_addr_map;
    logic [19:0] pats [6] = '{20'h40000, 20'h7FFFF, 20'h80000, 20'hAFFFF, 20'h9A5C3, 20'h5_1234};
    foreach (pats[i]) begin
      apply(pats[i], 1'b0, 1'b1, 1'b1);
      check("R5 ram addr", ram_addr, pats[i] & 20'h7FFFF);
    end
    apply(20'h80000, 1'b0, 1'b1, 1'b1);
    check("R5 paged low half", ram_addr, 19'h00000);
    apply(20'h40000, 1'b0, 1'b1, 1'b1);
    check("R5 direct upper half", ram_addr, 19'h40000);
  endtask

  task automatic t_direction;
    for (int s = 0; s < 4; s++) begin
      apply(20'h90010, s[0], s[1], 1'b0);
      check("R6 xcvr dir", xcvr_dir, s[0]);
      check("R6 xcvr en", xcvr_en_n, 0);
    end
  endtask

  task automatic t_indicators;
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 16; p++) begin
        bit active = !(s[0] && s[1]);
        bit host = (p < 4) || (p >= 12);
        apply({p[3:0], 16'h0100}, s[0], s[1], 1'b1);
        if (active) begin
          check("R7 sys led", sys_led_n, !host);
          check("R8 vid led", vid_led_n, !(p == 11));
        end else begin
          check("R9 sys dark", sys_led_n, 1);
          check("R9 vid dark", vid_led_n, 1);
          check("R9 ce unaffected", ram_ce_n, !covered(p, 1'b1));
        end
      end
  endtask

  initial begin
    bus_addr = '0; mem_rd_n = 1'b1; mem_wr_n = 1'b1; opt_page_en = 1'b0;
    repeat (2) @(posedge clk);
    t_idle_state();
    t_sweep_ce();
    t_addr_map();
    t_direction();
    t_indicators();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule